// File: doc/BRIEF.md
# Two-Port Interleaved Bank RAM

This block is an on-chip data RAM for a processor core with two load/store pipes. Storage is split into eight single-access banks of 512 words each, with 32-bit words. Consecutive word addresses are placed in consecutive banks. A linear stream therefore visits every bank once before it moves up one row. Two buffers that start in different banks can then be walked in lockstep by the two pipes without colliding.

Every cycle the block compares the bank fields of the two incoming requests. If they point at different banks, or only one port is requesting, both requests are served in that cycle. If both ports target the same bank, one request is accepted and the other is told to stall. The stalled requester keeps its request on its inputs, and the block accepts it in the very next cycle. The row does not matter, and neither does the mix of reads and writes.

Reads return data one cycle after acceptance. Writes take a per-byte enable mask.

Top module: `xbr_ram`

## Requirements
- R1: The 12-bit word address splits into a bank index in bits [2:0] and a row in bits [11:3], so word addresses 8 apart share a bank and words 1 apart do not.
- R2: A read accepted at a rising edge presents its word on that port's rdata, with rvalid high, during the following cycle only. An accepted write never raises rvalid.
- R3: On a write, be bit k enables byte lane k (wdata bits 8k+7..8k), and lanes whose enable is clear keep their previous contents.
- R4: When both ports request different banks in the same cycle, both are accepted and neither stall output is high.
- R5: When both ports request the same bank, exactly one stall output is high in that cycle, whatever the rows and whatever the read/write mix.
- R6: On a same-bank collision where neither port was stalled in the previous cycle, port 0 is accepted and port 1 stalls.
- R7: A port that stalled in the previous cycle and still presents its request is accepted in the current cycle, so no port stalls in two consecutive cycles.
- R8: A stalled request has no effect: a stalled write leaves memory untouched until it is accepted, and a stalled read produces no rvalid.
- R9: After reset both stall outputs and both rvalid outputs are low while no request is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| p0_req | input | 1 | Port 0 request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | 12 | Port 0 word address |
| p0_be | input | 4 | Port 0 byte-lane write enables |
| p0_wdata | input | 32 | Port 0 write data |
| p0_stall | output | 1 | Port 0 request not accepted this cycle |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | 32 | Port 0 read data |
| p1_req | input | 1 | Port 1 request |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | 12 | Port 1 word address |
| p1_be | input | 4 | Port 1 byte-lane write enables |
| p1_wdata | input | 32 | Port 1 write data |
| p1_stall | output | 1 | Port 1 request not accepted this cycle |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | 32 | Port 1 read data |

## Verification
The properties assume that a port seeing its stall output high presents the same request, with unchanged write flag, address, byte enables and data, in the following cycle. They also assume that inputs carry no unknown values once reset is released. The stimulus keeps to this by holding one operation queue per port and advancing a queue only in a cycle where the bench's own model says that port was accepted. Read addresses are confined to words written earlier in the run, so every returned word has a defined expected value.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

  // Which requester owns a bank in the current cycle
  typedef enum logic {
    SRC_P0 = 1'b0,
    SRC_P1 = 1'b1
  } xbr_src_e;

endpackage

// File: rtl/xbr_bank.sv
module xbr_bank #(
  parameter int ROWS = 512,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(ROWS)-1:0]  row,
  input  logic [DW/8-1:0]          be,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);

  localparam int BEW = DW / 8;

  logic [DW-1:0] mem_q [ROWS];
  logic [DW-1:0] rd_q;
  logic          wr_en;
  logic          rd_en;

  assign wr_en = en & we;
  assign rd_en = en & ~we;

  // Byte-lane write: only lanes with their enable set are updated
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < BEW; k++) begin
        if (be[k]) begin
          mem_q[row][k*8 +: 8] <= wdata[k*8 +: 8];
        end
      end
    end
  end

  // Registered read port, one cycle of latency
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem_q[row];
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/xbr_arb.sv
module xbr_arb #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic [BANK_W-1:0] p0_bank,
  input  logic              p1_req,
  input  logic [BANK_W-1:0] p1_bank,
  output logic              p0_gnt,
  output logic              p1_gnt
);

  logic collide;
  logic p1_first;
  logic p0_wait_q, p0_wait_d;
  logic p1_wait_q, p1_wait_d;
  logic upd_en;

  assign collide  = p0_req & p1_req & (p0_bank == p1_bank);
  // The port that lost last cycle takes precedence; otherwise port 0
  assign p1_first = p1_wait_q;

  assign p0_gnt = p0_req & ~(collide & p1_first);
  assign p1_gnt = p1_req & ~(collide & ~p1_first);

  always_comb begin
    p0_wait_d = p0_req & ~p0_gnt;
    p1_wait_d = p1_req & ~p1_gnt;
  end

  assign upd_en = p0_req | p1_req | p0_wait_q | p1_wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_wait_q <= 1'b0;
      p1_wait_q <= 1'b0;
    end else if (upd_en) begin
      p0_wait_q <= p0_wait_d;
      p1_wait_q <= p1_wait_d;
    end
  end

  AST_FREE_BANKS_BOTH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p1_req && (p0_bank != p1_bank)) |-> (p0_gnt && p1_gnt)) else $error("free banks"); // R4
  AST_COLLIDE_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> (p0_gnt != p1_gnt)) else $error("collision split"); // R5
  AST_FRESH_P0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !$past(p0_req && !p0_gnt) && !$past(p1_req && !p1_gnt)) |-> p0_gnt) else $error("p0 priority"); // R6
  AST_P1_NO_SECOND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && !p1_gnt) |=> (!p1_req || p1_gnt)) else $error("p1 stalled twice"); // R7
  AST_P0_NO_SECOND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && !p0_gnt) |=> (!p0_req || p0_gnt)) else $error("p0 stalled twice"); // R7

endmodule

// File: rtl/xbr_rsp.sv
module xbr_rsp #(
  parameter int BANKS  = 8,
  parameter int DW     = 32,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_fire,
  input  logic [BANK_W-1:0]          bank,
  input  logic [BANKS-1:0][DW-1:0]   bank_rdata,
  output logic                       rvalid,
  output logic [DW-1:0]              rdata
);

  logic              vld_q, vld_d;
  logic [BANK_W-1:0] sel_q, sel_d;
  logic              sel_en;

  always_comb begin
    vld_d  = rd_fire;
    sel_en = rd_fire;
    sel_d  = bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign rvalid = vld_q;
  assign rdata  = bank_rdata[sel_q];

  AST_READ_RETURNS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid) else $error("read lost"); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rvalid) else $error("spurious rvalid"); // R8

endmodule

// File: rtl/xbr_ram.sv
module xbr_ram #(
  parameter int BANKS = 8,
  parameter int ROWS  = 512,
  parameter int DW    = 32,
  parameter int AW    = $clog2(BANKS) + $clog2(ROWS),
  parameter int BEW   = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            p0_req,
  input  logic            p0_we,
  input  logic [AW-1:0]   p0_addr,
  input  logic [BEW-1:0]  p0_be,
  input  logic [DW-1:0]   p0_wdata,
  output logic            p0_stall,
  output logic            p0_rvalid,
  output logic [DW-1:0]   p0_rdata,
  input  logic            p1_req,
  input  logic            p1_we,
  input  logic [AW-1:0]   p1_addr,
  input  logic [BEW-1:0]  p1_be,
  input  logic [DW-1:0]   p1_wdata,
  output logic            p1_stall,
  output logic            p1_rvalid,
  output logic [DW-1:0]   p1_rdata
);

  import xbr_pkg::*;

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Address split: low bits pick the bank, the rest pick the row
  logic [BANK_W-1:0] p0_bank, p1_bank;
  logic [ROW_W-1:0]  p0_row,  p1_row;

  assign p0_bank = p0_addr[BANK_W-1:0];
  assign p1_bank = p1_addr[BANK_W-1:0];
  assign p0_row  = p0_addr[AW-1:BANK_W];
  assign p1_row  = p1_addr[AW-1:BANK_W];

  logic p0_gnt, p1_gnt;

  xbr_arb #(
    .BANK_W (BANK_W)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .p0_req  (p0_req),
    .p0_bank (p0_bank),
    .p1_req  (p1_req),
    .p1_bank (p1_bank),
    .p0_gnt  (p0_gnt),
    .p1_gnt  (p1_gnt)
  );

  assign p0_stall = p0_req & ~p0_gnt;
  assign p1_stall = p1_req & ~p1_gnt;

  // Per-bank request steering
  logic [BANKS-1:0][DW-1:0] bank_rdata;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic             hit0, hit1;
      xbr_src_e         src;
      logic             b_en, b_we;
      logic [ROW_W-1:0] b_row;
      logic [BEW-1:0]   b_be;
      logic [DW-1:0]    b_wdata;

      assign hit0 = p0_gnt & (p0_bank == BANK_W'(b));
      assign hit1 = p1_gnt & (p1_bank == BANK_W'(b));

      always_comb begin
        src     = hit0 ? SRC_P0 : SRC_P1;
        b_en    = hit0 | hit1;
        b_we    = (src == SRC_P0) ? p0_we    : p1_we;
        b_row   = (src == SRC_P0) ? p0_row   : p1_row;
        b_be    = (src == SRC_P0) ? p0_be    : p1_be;
        b_wdata = (src == SRC_P0) ? p0_wdata : p1_wdata;
      end

      xbr_bank #(
        .ROWS (ROWS),
        .DW   (DW)
      ) u_bank (
        .clk   (clk),
        .en    (b_en),
        .we    (b_we),
        .row   (b_row),
        .be    (b_be),
        .wdata (b_wdata),
        .rdata (bank_rdata[b])
      );

      AST_BANK_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !(hit0 && hit1)) else $error("bank double booked"); // R5
    end
  endgenerate

  // Read return paths
  logic p0_rd_fire, p1_rd_fire;

  assign p0_rd_fire = p0_gnt & ~p0_we;
  assign p1_rd_fire = p1_gnt & ~p1_we;

  xbr_rsp #(
    .BANKS (BANKS),
    .DW    (DW)
  ) u_rsp0 (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_fire    (p0_rd_fire),
    .bank       (p0_bank),
    .bank_rdata (bank_rdata),
    .rvalid     (p0_rvalid),
    .rdata      (p0_rdata)
  );

  xbr_rsp #(
    .BANKS (BANKS),
    .DW    (DW)
  ) u_rsp1 (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_fire    (p1_rd_fire),
    .bank       (p1_bank),
    .bank_rdata (bank_rdata),
    .rvalid     (p1_rvalid),
    .rdata      (p1_rdata)
  );

  AST_STALL_ONLY_ON_SHARED_BANK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (p0_stall || p1_stall) |-> (p0_req && p1_req && (p0_addr[BANK_W-1:0] == p1_addr[BANK_W-1:0]))) else $error("stall without collision"); // R1

endmodule

// File: tb/sim_xbr_ram.sv
module sim_xbr_ram;

  logic        clk;
  logic        rst_n;
  logic        p0_req, p0_we, p1_req, p1_we;
  logic [11:0] p0_addr, p1_addr;
  logic [3:0]  p0_be, p1_be;
  logic [31:0] p0_wdata, p1_wdata;
  logic        p0_stall, p0_rvalid, p1_stall, p1_rvalid;
  logic [31:0] p0_rdata, p1_rdata;

  xbr_ram u0 (
    .clk (clk), .rst_n (rst_n),
    .p0_req (p0_req), .p0_we (p0_we), .p0_addr (p0_addr), .p0_be (p0_be),
    .p0_wdata (p0_wdata), .p0_stall (p0_stall), .p0_rvalid (p0_rvalid), .p0_rdata (p0_rdata),
    .p1_req (p1_req), .p1_we (p1_we), .p1_addr (p1_addr), .p1_be (p1_be),
    .p1_wdata (p1_wdata), .p1_stall (p1_stall), .p1_rvalid (p1_rvalid), .p1_rdata (p1_rdata)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    bit          req;
    bit          we;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    string       tag;
  } op_t;

  typedef struct {
    int          due;
    logic [31:0] data;
    string       tag;
  } exp_t;

  op_t  q0[$], q1[$];
  exp_t e0[$], e1[$];
  logic [31:0] ref_mem [4096];
  int   cyc    = 0;
  int   checks = 0;
  int   fails  = 0;
  bit   p0_waited = 0, p1_waited = 0;
  bit   finished  = 0;
  bit [31:0] rng = 32'h1234_5678;

  function automatic bit [31:0] nxt();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic op_t mk(bit req, bit we, int addr, logic [3:0] be, logic [31:0] wd, string tag);
    op_t o;
    o.req = req; o.we = we; o.addr = addr[11:0]; o.be = be; o.wd = wd; o.tag = tag;
    return o;
  endfunction

  // Monitor: pops expected reads as results appear (R2)
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (p0_rvalid === 1'b1) begin
      if (e0.size() == 0) chk(0, "R2 p0 rvalid with no read pending", 1, 0);
      else begin
        e = e0.pop_front();
        chk(e.due == cyc, "R2 p0 read latency", cyc, e.due);
        chk(p0_rdata === e.data, {e.tag, " p0 read data"}, p0_rdata, e.data);
      end
    end else if (e0.size() > 0 && e0[0].due <= cyc) begin
      e = e0.pop_front();
      chk(0, "R2 p0 missing rvalid", 0, 1);
    end
    if (p1_rvalid === 1'b1) begin
      if (e1.size() == 0) chk(0, "R2 p1 rvalid with no read pending", 1, 0);
      else begin
        e = e1.pop_front();
        chk(e.due == cyc, "R2 p1 read latency", cyc, e.due);
        chk(p1_rdata === e.data, {e.tag, " p1 read data"}, p1_rdata, e.data);
      end
    end else if (e1.size() > 0 && e1[0].due <= cyc) begin
      e = e1.pop_front();
      chk(0, "R2 p1 missing rvalid", 0, 1);
    end
  end

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = wd[k*8 +: 8];
    return r;
  endfunction

  // Driver: presents queue heads, advances a queue only on acceptance
  task automatic run_ops();
    op_t   h0, h1;
    bit    col, p1_wins, acc0, acc1;
    string tag;
    exp_t  x;
    while (q0.size() > 0 || q1.size() > 0) begin
      @(negedge clk);
      #1;
      h0 = (q0.size() > 0) ? q0[0] : mk(0, 0, 0, 0, 0, "");
      h1 = (q1.size() > 0) ? q1[0] : mk(0, 0, 0, 0, 0, "");
      p0_req = h0.req; p0_we = h0.we; p0_addr = h0.addr; p0_be = h0.be; p0_wdata = h0.wd;
      p1_req = h1.req; p1_we = h1.we; p1_addr = h1.addr; p1_be = h1.be; p1_wdata = h1.wd;
      #1;
      // R1: bank is word-address bits [2:0]
      col     = h0.req && h1.req && (h0.addr[2:0] == h1.addr[2:0]);
      p1_wins = p1_waited;
      acc0    = h0.req && !(col && p1_wins);
      acc1    = h1.req && !(col && !p1_wins);
      if (col) tag = p1_wins ? "R7 stalled port first" : (p0_waited ? "R7 stalled port first" : "R6 port0 wins fresh collision");
      else     tag = (h0.req && h1.req) ? "R4 distinct banks" : "R1 single requester";
      chk(p0_stall === (h0.req && !acc0), {tag, " p0_stall"}, p0_stall, h0.req && !acc0);
      chk(p1_stall === (h1.req && !acc1), {tag, " p1_stall"}, p1_stall, h1.req && !acc1);
      if (col) chk((p0_stall ^ p1_stall) === 1'b1, "R5 exactly one stall on shared bank", p0_stall ^ p1_stall, 1);
      // reads see memory before this cycle's writes
      if (acc0 && !h0.we) begin x.due = cyc + 1; x.data = ref_mem[h0.addr]; x.tag = h0.tag; e0.push_back(x); end
      if (acc1 && !h1.we) begin x.due = cyc + 1; x.data = ref_mem[h1.addr]; x.tag = h1.tag; e1.push_back(x); end
      if (acc0 && h0.we) ref_mem[h0.addr] = merge(ref_mem[h0.addr], h0.wd, h0.be);
      if (acc1 && h1.we) ref_mem[h1.addr] = merge(ref_mem[h1.addr], h1.wd, h1.be);
      if (q0.size() > 0 && (!h0.req || acc0)) void'(q0.pop_front());
      if (q1.size() > 0 && (!h1.req || acc1)) void'(q1.pop_front());
      p0_waited = h0.req && !acc0;
      p1_waited = h1.req && !acc1;
    end
    @(negedge clk);
    #1;
    p0_req = 0; p1_req = 0;
  endtask

  initial begin
    p0_req = 0; p0_we = 0; p0_addr = 0; p0_be = 0; p0_wdata = 0;
    p1_req = 0; p1_we = 0; p1_addr = 0; p1_be = 0; p1_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R9: quiet outputs after reset
    chk(p0_stall === 1'b0, "R9 p0_stall after reset", p0_stall, 0);
    chk(p1_stall === 1'b0, "R9 p1_stall after reset", p1_stall, 0);
    chk(p0_rvalid === 1'b0, "R9 p0_rvalid after reset", p0_rvalid, 0);
    chk(p1_rvalid === 1'b0, "R9 p1_rvalid after reset", p1_rvalid, 0);

    // Fill: banks always 4 apart, no collisions (R4)
    for (int i = 0; i < 64; i++) begin
      q0.push_back(mk(1, 1, i,      4'hF, 32'hA000_0000 + i, "R2"));
      q1.push_back(mk(1, 1, 68 + i, 4'hF, 32'hB000_0000 + i, "R2"));
    end
    run_ops();

    // Same bank, different rows, every cycle (R5, R6, R7)
    for (int i = 0; i < 16; i++) begin
      q0.push_back(mk(1, 0, i,      4'h0, 0, "R5"));
      q1.push_back(mk(1, 0, 72 + i, 4'h0, 0, "R5"));
    end
    run_ops();

    // R1: words 8 apart share a bank; write against read also collides (R5)
    q0.push_back(mk(1, 1, 8,  4'hF, 32'h0808_0808, "R1"));
    q1.push_back(mk(1, 1, 16, 4'hF, 32'h1616_1616, "R1"));
    q0.push_back(mk(1, 1, 2,  4'hF, 32'h0202_0202, "R5"));
    q1.push_back(mk(1, 0, 74, 4'h0, 0,             "R5"));
    q0.push_back(mk(1, 0, 8,  4'h0, 0, "R1"));
    q1.push_back(mk(1, 0, 16, 4'h0, 0, "R1"));
    run_ops();

    // R3: partial byte write
    q0.push_back(mk(1, 1, 5, 4'hF, 32'hAABB_CCDD, "R3"));
    q0.push_back(mk(1, 1, 5, 4'b0101, 32'h1122_3344, "R3"));
    q0.push_back(mk(1, 0, 5, 4'h0, 0, "R3 expect AA22CC44"));
    run_ops();

    // R8: stalled write must not be visible to the winning read
    q0.push_back(mk(1, 0, 11, 4'h0, 0, "R8 read during stalled write"));
    q1.push_back(mk(1, 1, 11, 4'hF, 32'hDEAD_0011, "R8"));
    q0.push_back(mk(0, 0, 0, 4'h0, 0, ""));
    q0.push_back(mk(1, 0, 11, 4'h0, 0, "R8 write lands after stall"));
    run_ops();

    // Mixed traffic
    for (int i = 0; i < 300; i++) begin
      q0.push_back(mk((nxt() % 8) != 0, nxt() % 2, nxt() % 64,      nxt() % 16, nxt(), "R2 mixed"));
      q1.push_back(mk((nxt() % 8) != 0, nxt() % 2, 68 + nxt() % 64, nxt() % 16, nxt(), "R2 mixed"));
    end
    run_ops();

    repeat (4) @(negedge clk);
    #1;
    chk(e0.size() == 0, "R2 p0 reads left unanswered", e0.size(), 0);
    chk(e1.size() == 0, "R2 p1 reads left unanswered", e1.size(), 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

endmodule